// File: doc/BRIEF.md
# Banked Scratchpad Read Scheduler

This block takes one read request from each of 16 lanes in a single cycle. Each request is a word address with a valid bit. It returns the 32-bit word each valid lane asked for. The words live in a memory of 16 word-wide banks, and consecutive word addresses fall in consecutive banks. In one pass, each bank can supply only one word. Requests are therefore served over as many passes as the bank conflicts inside the group require.

In every pass one word is chosen for broadcast: the word asked for by the lowest-numbered lane still waiting. Every waiting lane that names that word is served together. In each other bank, the lowest-numbered waiting lane wins. Lanes that lose wait for a later pass, even if they ask for the same word as the winner. When every valid lane holds its data, `done` rises and the number of passes used appears on `pass_count`. The memory is filled beforehand through a plain write port.

Top module: `banked_read_scheduler`

## Requirements
- R1: A word address selects bank = address bits [3:0] and row = the remaining upper bits. When `done` is high, every valid lane's data output equals the word last written to its address.
- R2: When all valid lanes address distinct banks, the group completes in exactly one pass.
- R3: When all valid lanes address the same word, the group completes in exactly one pass.
- R4: Each pass broadcasts the word of the lowest-numbered pending lane and serves every pending lane that addresses that word. Other pending lanes in the broadcast word's bank wait.
- R5: In every bank other than the broadcast bank, only the lowest-numbered pending lane is served in a pass. A lane naming the same word as that winner still waits for a later pass.
- R6: Lanes that address different words of one bank are served in separate passes. `pass_count` equals the number of passes used by the policy of R4 and R5.
- R7: Each pass takes one cycle. `done` rises exactly P+1 clock edges after the edge that accepts `start`, where P is the pass count. `done` then stays high with all data present until the next accepted `start`.
- R8: `start` is accepted only while no group is in progress. A `start` pulse during a group changes neither the results nor the pass count of that group.
- R9: Invalid lanes take no part in arbitration, and their data outputs are zero when `done` rises. A group with no valid lane finishes with `pass_count` = 0.
- R10: After reset, `done` is low, `pass_count` is zero and all lane data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | 10 | Preload word address |
| wr_data | input | 32 | Preload word |
| start | input | 1 | Capture a new request group |
| lane_valid | input | 16 | Per-lane request valid |
| lane_addr | input | 160 | Per-lane word address, lane i at bits [10*i+9:10*i] |
| lane_data | output | 512 | Per-lane returned word, lane i at bits [32*i+31:32*i] |
| done | output | 1 | All valid lanes served |
| pass_count | output | 5 | Passes used by the last group |

## Verification
Each group pattern is chosen so that a wrong policy gives a different pass count or latency:
- Lanes spread over distinct banks, and lanes all naming one word, must each finish in a single pass.
- Two lane pairs sharing two words must take two passes. So must a broadcast word followed by three lanes sharing one non-broadcast word. A merging scheduler would finish either group in one pass.
- A pattern where the broadcast word's bank also holds other requested words shows that those other words are deferred.
- Sixteen different rows of bank 0 must take sixteen passes. A `start` pulse is injected in the middle of this group, and the unchanged results show it was ignored.
- Groups with partly valid lanes, groups with no valid lane, and pseudo-random groups over a narrow address range cover the remaining orderings.

// File: rtl/brs_pkg.sv
// Package: shared types for the banked read scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package brs_pkg;

    // Controller phases of one request group.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_DRAIN = 2'd2
    } brs_state_e;

endpackage

// File: rtl/brs_bank.sv
// Module: one word-wide memory bank with a preload write port and a
// registered read port (one-cycle latency).
// Assumes: write and read to the same row in one cycle is not needed.
module brs_bank #(
    parameter int ROW_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store preload words.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_row] <= wr_data;
        end
    end

    // Registered read of the row chosen for this pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_row];
        end
    end

endmodule

// File: rtl/brs_pass_arbiter.sv
// Module: combinational pass arbiter. It picks the broadcast word
// (the word of the lowest pending lane) and, for each other bank, the
// lowest pending lane. It returns the lanes served this pass and the
// row each bank must read.
// Assumes: the pending mask holds only valid lanes.
module brs_pass_arbiter #(
    parameter int LANES     = 16,
    parameter int BANK_BITS = 4,
    parameter int ADDR_W    = 10
) (
    input  logic [LANES-1:0]                          pending,
    input  logic [LANES-1:0][ADDR_W-1:0]              addr,
    output logic [LANES-1:0]                          grant,
    output logic [(1<<BANK_BITS)-1:0]                 bank_en,
    output logic [(1<<BANK_BITS)-1:0][ADDR_W-BANK_BITS-1:0] bank_row
);
    localparam int BANKS = 1 << BANK_BITS;
    localparam int ROW_W = ADDR_W - BANK_BITS;

    logic              lead_found;
    logic [ADDR_W-1:0] bc_addr;
    logic [BANK_BITS-1:0] bc_bank;

    // Locate the lowest pending lane; its word is broadcast.
    always_comb begin
        lead_found = 1'b0;
        bc_addr    = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pending[i] && !lead_found) begin
                lead_found = 1'b1;
                bc_addr    = addr[i];
            end
        end
    end

    assign bc_bank = bc_addr[BANK_BITS-1:0];

    // Serve broadcast matches, then the lowest pending lane of each other bank.
    always_comb begin
        grant    = '0;
        bank_en  = '0;
        bank_row = '0;
        if (lead_found) begin
            bank_en[bc_bank]  = 1'b1;
            bank_row[bc_bank] = bc_addr[ADDR_W-1:BANK_BITS];
        end
        for (int i = 0; i < LANES; i++) begin
            if (pending[i]) begin
                if (addr[i] == bc_addr) begin
                    grant[i] = 1'b1;
                end else if ((addr[i][BANK_BITS-1:0] != bc_bank) &&
                             !bank_en[addr[i][BANK_BITS-1:0]]) begin
                    grant[i] = 1'b1;
                    bank_en[addr[i][BANK_BITS-1:0]]  = 1'b1;
                    bank_row[addr[i][BANK_BITS-1:0]] = addr[i][ADDR_W-1:BANK_BITS];
                end
            end
        end
    end

    // Immediate check: no lane is granted unless it is pending.
    always_comb begin
        if (BANKS > 0 && ROW_W > 0) begin
            AST_GRANT_ONLY_PENDING: assert ((grant & ~pending) == '0); // R9
        end
    end

endmodule

// File: rtl/banked_read_scheduler.sv
// Module: top of the banked read scheduler. It captures a group of lane
// requests on start and runs one arbitration pass per cycle until all
// valid lanes are served. Bank data is written to the lanes one cycle
// after each pass. It then raises done together with the pass count.
// Assumes: preload writes happen while no group is in progress.
module banked_read_scheduler
    import brs_pkg::*;
#(
    parameter int LANES     = 16,
    parameter int BANK_BITS = 4,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     start,
    input  logic [LANES-1:0]         lane_valid,
    input  logic [LANES*ADDR_W-1:0]  lane_addr,
    output logic [LANES*DATA_W-1:0]  lane_data,
    output logic                     done,
    output logic [$clog2(LANES+1)-1:0] pass_count
);
    localparam int BANKS = 1 << BANK_BITS;
    localparam int ROW_W = ADDR_W - BANK_BITS;
    localparam int CNT_W = $clog2(LANES + 1);

    brs_state_e                      state_q;
    logic [LANES-1:0]                valid_q;
    logic [LANES-1:0]                pending_q;
    logic [LANES-1:0]                grant_q;
    logic [LANES-1:0][ADDR_W-1:0]    addr_q;
    logic [LANES-1:0][DATA_W-1:0]    data_q;
    logic [CNT_W-1:0]                pass_cnt_q;
    logic                            done_q;

    logic [LANES-1:0]                grant;
    logic [BANKS-1:0]                bank_en;
    logic [BANKS-1:0][ROW_W-1:0]     bank_row;
    logic [BANKS-1:0][DATA_W-1:0]    bank_rdata;
    logic                            in_pass;

    assign in_pass = (state_q == ST_BUSY);

    brs_pass_arbiter #(
        .LANES     (LANES),
        .BANK_BITS (BANK_BITS),
        .ADDR_W    (ADDR_W)
    ) arb_i (
        .pending  (pending_q),
        .addr     (addr_q),
        .grant    (grant),
        .bank_en  (bank_en),
        .bank_row (bank_row)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        brs_bank #(
            .ROW_W  (ROW_W),
            .DATA_W (DATA_W)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_addr[BANK_BITS-1:0] == BANK_BITS'(b))),
            .wr_row  (wr_addr[ADDR_W-1:BANK_BITS]),
            .wr_data (wr_data),
            .rd_en   (in_pass && bank_en[b]),
            .rd_row  (bank_row[b]),
            .rd_data (bank_rdata[b])
        );
    end

    // Group control: capture, one pass per cycle, final data capture, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            valid_q    <= '0;
            pending_q  <= '0;
            grant_q    <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            pass_cnt_q <= '0;
            done_q     <= 1'b0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (grant_q[i]) begin
                    data_q[i] <= bank_rdata[addr_q[i][BANK_BITS-1:0]];
                end
            end
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        valid_q    <= lane_valid;
                        pending_q  <= lane_valid;
                        grant_q    <= '0;
                        data_q     <= '0;
                        pass_cnt_q <= '0;
                        done_q     <= 1'b0;
                        for (int i = 0; i < LANES; i++) begin
                            addr_q[i] <= lane_addr[i*ADDR_W +: ADDR_W];
                        end
                        state_q <= (|lane_valid) ? ST_BUSY : ST_DRAIN;
                    end
                end
                ST_BUSY: begin
                    pending_q  <= pending_q & ~grant;
                    grant_q    <= grant;
                    pass_cnt_q <= pass_cnt_q + CNT_W'(1);
                    if ((pending_q & ~grant) == '0) begin
                        state_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    grant_q <= '0;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Flatten per-lane data onto the output bus.
    for (genvar i = 0; i < LANES; i++) begin : g_out
        assign lane_data[i*DATA_W +: DATA_W] = data_q[i];
    end

    assign done       = done_q;
    assign pass_count = pass_cnt_q;

    // Assertions guarding the pass loop.
    AST_PASS_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        in_pass |-> (grant != '0)); // R6

    AST_PENDING_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_pass |-> ((grant & ~valid_q) == '0)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(valid_q)); // R8

    AST_DONE_ALL_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (pending_q == '0)); // R7

    AST_PASS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (32'(pass_cnt_q) <= $countones(valid_q))); // R6

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (done_q && !valid_q[i]) |-> (data_q[i] == '0)); // R9
        for (genvar j = i + 1; j < LANES; j++) begin : g_pair
            AST_BANK_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
                (in_pass && grant[i] && grant[j] &&
                 (addr_q[i][BANK_BITS-1:0] == addr_q[j][BANK_BITS-1:0]))
                |-> (addr_q[i] == addr_q[j])); // R6
        end
    end

endmodule

// File: tb/banked_read_scheduler_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results into a queue, and
// the monitor pops and compares them when done rises.
module banked_read_scheduler_tb_top;
    localparam int LANES  = 16;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int CNT_W  = $clog2(LANES + 1);

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     wr_en = 1'b0;
    logic [ADDR_W-1:0]        wr_addr = '0;
    logic [DATA_W-1:0]        wr_data = '0;
    logic                     start = 1'b0;
    logic [LANES-1:0]         lane_valid = '0;
    logic [LANES*ADDR_W-1:0]  lane_addr = '0;
    logic [LANES*DATA_W-1:0]  lane_data;
    logic                     done;
    logic [CNT_W-1:0]         pass_count;

    typedef struct {
        logic [LANES*DATA_W-1:0] data;
        int                      passes;
        string                   req;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          start_cyc = 0;
    bit          mon_done = 1'b0;
    bit          prev_done = 1'b0;
    logic [31:0] ref_mem [DEPTH];
    logic [31:0] lcg = 32'h1234_5678;

    banked_read_scheduler dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .start      (start),
        .lane_valid (lane_valid),
        .lane_addr  (lane_addr),
        .lane_data  (lane_data),
        .done       (done),
        .pass_count (pass_count)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Record one comparison.
    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Pass count predicted from the requirement's policy (R4, R5).
    function automatic int model_passes(logic [LANES-1:0] v, int a[LANES]);
        logic [LANES-1:0] p;
        int n;
        p = v;
        n = 0;
        while (p != '0) begin
            int lead;
            int bc;
            logic [15:0] taken;
            logic [LANES-1:0] g;
            lead = -1;
            for (int i = 0; i < LANES; i++) if (p[i] && lead < 0) lead = i;
            bc = a[lead];
            taken = '0;
            taken[bc % 16] = 1'b1;
            g = '0;
            for (int i = 0; i < LANES; i++) begin
                if (p[i]) begin
                    if (a[i] == bc) g[i] = 1'b1;
                    else if (!taken[a[i] % 16]) begin
                        taken[a[i] % 16] = 1'b1;
                        g[i] = 1'b1;
                    end
                end
            end
            p = p & ~g;
            n++;
        end
        return n;
    endfunction

    // Driver: push the expectation, issue the group, wait for the monitor.
    task automatic run_group(string req, logic [LANES-1:0] v, int a[LANES], bit poke);
        exp_t e;
        e.data = '0;
        for (int i = 0; i < LANES; i++)
            if (v[i]) e.data[i*DATA_W +: DATA_W] = ref_mem[a[i]];
        e.passes = model_passes(v, a);
        e.req = req;
        exp_q.push_back(e);
        mon_done = 1'b0;
        @(negedge clk);
        lane_valid = v;
        for (int i = 0; i < LANES; i++) lane_addr[i*ADDR_W +: ADDR_W] = ADDR_W'(a[i]);
        start = 1'b1;
        @(posedge clk);
        #1 start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            lane_valid = '1;
            for (int i = 0; i < LANES; i++) lane_addr[i*ADDR_W +: ADDR_W] = ADDR_W'(i + 7);
            start = 1'b1;  // R8: must be ignored mid-group
            @(negedge clk);
            start = 1'b0;
        end
        while (!mon_done) @(negedge clk);
    endtask

    // Monitor: on each rise of done, pop and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (done && !prev_done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    for (int i = 0; i < LANES; i++)
                        check(lane_data[i*DATA_W +: DATA_W] == e.data[i*DATA_W +: DATA_W],
                              "R1/R9", $sformatf("lane %0d data", i),
                              lane_data[i*DATA_W +: DATA_W], e.data[i*DATA_W +: DATA_W]);
                    check(int'(pass_count) == e.passes, e.req, "pass count",
                          pass_count, e.passes);
                    check(cyc - start_cyc == e.passes + 1, "R7", "done latency",
                          cyc - start_cyc, e.passes + 1);
                end
                mon_done = 1'b1;
            end
            prev_done = done;
        end
    end

    // Watchdog.
    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic int next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return int'(lcg[23:8]);
    endfunction

    initial begin
        int a[LANES];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(done == 1'b0, "R10", "done after reset", done, 0);
        check(pass_count == '0, "R10", "pass_count after reset", pass_count, 0);
        check(lane_data == '0, "R10", "lane data after reset", lane_data[31:0], 0);

        // Preload every word.
        for (int w = 0; w < DEPTH; w++) begin
            ref_mem[w] = (32'(w) * 32'h0100_0193) ^ 32'h5A5A_C3C3;
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = ADDR_W'(w);
            wr_data = ref_mem[w];
        end
        @(negedge clk);
        wr_en = 1'b0;

        // R2: distinct banks
        for (int i = 0; i < LANES; i++) a[i] = i + 16 * ((i * 5) % 64);
        run_group("R2", '1, a, 1'b0);

        // R3: all lanes on one word
        for (int i = 0; i < LANES; i++) a[i] = 300;
        run_group("R3", '1, a, 1'b0);

        // R5: two pairs on two words, only one broadcast
        for (int i = 0; i < LANES; i++) a[i] = (i < 2) ? 0 : 1;
        run_group("R5", 16'h000F, a, 1'b0);

        // R4: broadcast bank holds other requested words
        for (int i = 0; i < LANES; i++) a[i] = 3;
        a[1] = 19; a[3] = 35;
        run_group("R4", 16'h000F, a, 1'b0);

        // R5: non-broadcast shared word is serialized
        for (int i = 0; i < LANES; i++) a[i] = 5;
        a[0] = 2;
        run_group("R5", 16'h000F, a, 1'b0);

        // R6 and R8: sixteen rows of bank 0, with a start poke mid-group
        for (int i = 0; i < LANES; i++) a[i] = 16 * i;
        run_group("R6", '1, a, 1'b1);

        // R9: partly valid lanes
        for (int i = 0; i < LANES; i++) a[i] = next_rand() % 48;
        run_group("R9", 16'hA5C3, a, 1'b0);

        // R9: no valid lane
        run_group("R9", '0, a, 1'b0);

        // R6: pseudo-random groups with conflicts
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < LANES; i++) a[i] = next_rand() % 64;
            run_group("R6", 16'(next_rand()) | 16'h0001, a, 1'b0);
        end

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule